// File: doc/BRIEF.md
# USB Host Controller Operational Control Register Block

This block holds the operational control word of a USB host controller core, together with a read-only revision word. Host software reaches both through a small byte-wide register bus. Each 32-bit word occupies four consecutive byte offsets, and byte offset n of a word holds bits [8n+7:8n]. Writes take effect at the clock edge. Reads are combinational and are never held off.

The control word sets the host's functional state. It also holds the enables for the four transfer lists, the control-to-bulk service ratio, the interrupt routing choice and the remote wakeup bits. The block drives these decoded fields straight to the scheduler, and it steers the core's interrupt request onto either the normal interrupt line or the system-management interrupt line.

The functional state is a four-state machine with the states RESET (00), RESUME (01), OPERATIONAL (10) and SUSPEND (11). A software write to control byte 0 moves the machine from any state to the state written. There is one hardware transition: a resume event from any downstream port while the machine is in SUSPEND forces SUSPEND -> RESUME. This transition wins over a software write in the same cycle. In every other case the state holds.

Top module: `hc_opctl_regs`

## Requirements
- R1: After reset, every control field is zero: the state is RESET, all list enables are 0, the ratio is 00, routing is 0 and wake enable is 0. Control bytes at offsets 4 and 5 read 00h.
- R2: Offset 0 reads 10h and offsets 1 to 3 read 00h. Writes to offsets 0 to 3 change nothing.
- R3: Control byte 0 (offset 4) holds the service ratio in bits [1:0], the periodic enable in bit 2, the isochronous enable in bit 3, the control-list enable in bit 4 and the bulk-list enable in bit 5. A write drives these fields to the outputs on the next cycle, and a read returns them.
- R4: Bits [7:6] of offset 4 hold the state (00 RESET, 01 RESUME, 10 OPERATIONAL, 11 SUSPEND). Software can write any of the four values.
- R5: In SUSPEND, a 1 on any bit of `port_resume` puts the state in RESUME on the next cycle.
- R6: Outside SUSPEND, `port_resume` has no effect on the state.
- R7: When a software state write and a SUSPEND resume event fall in the same cycle, the state becomes RESUME. The other bits written to offset 4 still take effect.
- R8: In control byte 1 (offset 5), bit 0 is the interrupt routing bit and bit 2 is a writable wake enable that changes no output. Bit 1 (wake connected) always reads 0.
- R9: With routing 0, `irq_req` appears on `intr_o` and `smi_o` is 0. With routing 1, it appears on `smi_o` and `intr_o` is 0.
- R10: Bits [7:3] of offset 5 and all of offsets 6 and 7 read 0, and writes to them are discarded.
- R11: Offsets above 7 read 00h, and reads return data in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte at `bus_addr` |
| port_resume | input | 4 | Resume detected, one bit per downstream port |
| irq_req | input | 1 | Interrupt request from the core |
| intr_o | output | 1 | Normal interrupt line |
| smi_o | output | 1 | System-management interrupt line |
| host_state | output | 2 | Functional state |
| list_periodic | output | 1 | Periodic list enable |
| list_iso | output | 1 | Isochronous list enable |
| list_ctrl | output | 1 | Control list enable |
| list_bulk | output | 1 | Bulk list enable |
| cb_ratio | output | 2 | Control-to-bulk service ratio |

## Verification
Assertions check three things on every cycle. They check the forced SUSPEND -> RESUME step, that the state holds outside SUSPEND when there is no write, and that a software write lands when no resume forces the state. They also check that at most one interrupt line is active, that the wake-connected bit reads 0, and that a read of control byte 0 matches the driven outputs. The bench scenarios cover the facts that only a sequence can show: the reset values, the fixed revision value under writes, the priority of a resume over a software write in the same cycle, the discarding of writes to reserved bits, and zero reads from unmapped offsets.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
    typedef enum logic [1:0] {
        HS_RESET   = 2'b00,
        HS_RESUME  = 2'b01,
        HS_OPER    = 2'b10,
        HS_SUSPEND = 2'b11
    } hstate_e;

    // bit order matches control byte 0 [5:0]
    typedef struct packed {
        logic       bulk_en;
        logic       ctl_en;
        logic       iso_en;
        logic       per_en;
        logic [1:0] ratio;
    } lists_t;

    localparam int unsigned OFF_REV0 = 0;
    localparam int unsigned OFF_CTL0 = 4;
    localparam int unsigned OFF_CTL1 = 5;
    localparam int unsigned OFF_LAST = 7;
endpackage

// File: rtl/hcr_state_fsm.sv
module hcr_state_fsm
    import hcr_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_state,
    input  logic [NPORTS-1:0] resume_det,
    output hstate_e           state_o
);
    hstate_e state_q, state_d;
    logic    any_resume;

    assign any_resume = |resume_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_SUSPEND: begin
                if (any_resume) state_d = HS_RESUME;
                else if (sw_wr) state_d = hstate_e'(sw_state);
            end
            HS_RESET, HS_RESUME, HS_OPER: begin
                if (sw_wr) state_d = hstate_e'(sw_state);
            end
            default: state_d = HS_RESET;
        endcase
    end

    assign state_o = state_q;

    // R5
    resume_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_SUSPEND && any_resume) |=> state_q == HS_RESUME);

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && state_q != HS_SUSPEND) |=> $stable(state_q));

    // R4
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !(state_q == HS_SUSPEND && any_resume)) |=> state_q == $past(sw_state));
endmodule

// File: rtl/hcr_ctl_fields.sv
module hcr_ctl_fields
    import hcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output lists_t            lists_o,
    output logic              route_o,
    output logic              wake_en_o,
    output logic              ctl0_wr_o
);
    logic ctl1_wr;

    assign ctl0_wr_o = wr && (addr == ADDR_W'(OFF_CTL0));
    assign ctl1_wr   = wr && (addr == ADDR_W'(OFF_CTL1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lists_o   <= '0;
            route_o   <= 1'b0;
            wake_en_o <= 1'b0;
        end else begin
            if (ctl0_wr_o) lists_o <= lists_t'(wdata[5:0]);
            if (ctl1_wr) begin
                route_o   <= wdata[0];
                wake_en_o <= wdata[2];
            end
        end
    end
endmodule

// File: rtl/hcr_read_mux.sv
module hcr_read_mux
    import hcr_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [7:0] REV    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  hstate_e           state,
    input  lists_t            lists,
    input  logic              route,
    input  logic              wake_en,
    output logic [7:0]        rdata
);
    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_W'(OFF_REV0))      rdata = REV;
        else if (addr == ADDR_W'(OFF_CTL0)) rdata = {state, lists};
        else if (addr == ADDR_W'(OFF_CTL1)) rdata = {5'b0, wake_en, 1'b0, route};
    end

    // R8
    wake_conn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_CTL1)) |-> !rdata[1]);
endmodule

// File: rtl/hc_opctl_regs.sv
module hc_opctl_regs
    import hcr_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         NPORTS = 4,
    parameter logic [7:0] REV    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NPORTS-1:0] port_resume,
    input  logic              irq_req,
    output logic              intr_o,
    output logic              smi_o,
    output logic [1:0]        host_state,
    output logic              list_periodic,
    output logic              list_iso,
    output logic              list_ctrl,
    output logic              list_bulk,
    output logic [1:0]        cb_ratio
);
    hstate_e state;
    lists_t  lists;
    logic    route, wake_en, ctl0_wr;

    hcr_ctl_fields #(.ADDR_W(ADDR_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .lists_o(lists), .route_o(route), .wake_en_o(wake_en), .ctl0_wr_o(ctl0_wr)
    );

    hcr_state_fsm #(.NPORTS(NPORTS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_wr(ctl0_wr), .sw_state(bus_wdata[7:6]),
        .resume_det(port_resume), .state_o(state)
    );

    hcr_read_mux #(.ADDR_W(ADDR_W), .REV(REV)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .state(state), .lists(lists),
        .route(route), .wake_en(wake_en), .rdata(bus_rdata)
    );

    assign host_state    = state;
    assign list_periodic = lists.per_en;
    assign list_iso      = lists.iso_en;
    assign list_ctrl     = lists.ctl_en;
    assign list_bulk     = lists.bulk_en;
    assign cb_ratio      = lists.ratio;
    assign intr_o        = irq_req && !route;
    assign smi_o         = irq_req && route;

    // R9
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({intr_o, smi_o}) && (irq_req == (intr_o | smi_o)));

    // R3
    ctl0_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTL0)) |->
        bus_rdata == {host_state, list_bulk, list_ctrl, list_iso, list_periodic, cb_ratio});

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(OFF_LAST)) |-> bus_rdata == 8'h00);
endmodule

// File: tb/test_hc_opctl_regs.sv
`timescale 1ns/100ps
module test_hc_opctl_regs;
    logic       clk = 0, rst_n = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic       bus_wr = 0, irq_req = 0, intr_o, smi_o;
    logic [3:0] port_resume = 0;
    logic [1:0] host_state, cb_ratio;
    logic       list_periodic, list_iso, list_ctrl, list_bulk;

    int total = 0, bad = 0;
    bit done = 0;

    logic [1:0] m_state;
    logic [5:0] m_lists;
    logic       m_route, m_wake;

    always #5 clk = ~clk;

    hc_opctl_regs i_hc_opctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_resume(port_resume),
        .irq_req(irq_req), .intr_o(intr_o), .smi_o(smi_o), .host_state(host_state),
        .list_periodic(list_periodic), .list_iso(list_iso), .list_ctrl(list_ctrl),
        .list_bulk(list_bulk), .cb_ratio(cb_ratio)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'd0:    return 8'h10;
            8'd4:    return {m_state, m_lists};
            8'd5:    return {5'b0, m_wake, 1'b0, m_route};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        if (a < 4)  return "R2";
        if (a == 4) return "R3";
        if (a == 5) return "R8";
        if (a < 8)  return "R10";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input logic [3:0] res);
        bus_wr = wr; bus_addr = a; bus_wdata = d; port_resume = res;
        @(posedge clk);
        if (m_state == 2'b11 && |res) m_state = 2'b01;
        else if (wr && a == 8'd4)     m_state = d[7:6];
        if (wr && a == 8'd4) m_lists = d[5:0];
        if (wr && a == 8'd5) begin m_route = d[0]; m_wake = d[2]; end
        @(negedge clk);
        bus_wr = 0; port_resume = 0;
    endtask

    task automatic read_chk(input logic [7:0] a, input string req);
        bus_addr = a; #1;
        check(req, {24'b0, bus_rdata}, {24'b0, exp_read(a)});
    endtask

    task automatic out_chk(input string req);
        #1;
        check(req, {22'b0, host_state, list_bulk, list_ctrl, list_iso, list_periodic, cb_ratio},
              {22'b0, m_state, m_lists});
    endtask

    task automatic irq_chk(input logic r, input string req);
        irq_req = r; #1;
        check(req, {30'b0, intr_o, smi_o}, {30'b0, r && !m_route, r && m_route});
        irq_req = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            check("watchdog", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed);
        m_state = 0; m_lists = 0; m_route = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        out_chk("R1");
        read_chk(8'd4, "R1");
        read_chk(8'd5, "R1");
        read_chk(8'd0, "R2");
        // R2 revision ignores writes
        cyc(1, 8'd0, 8'hFF, 0); read_chk(8'd0, "R2");
        cyc(1, 8'd3, 8'hFF, 0); read_chk(8'd3, "R2");
        // R3 field layout
        cyc(1, 8'd4, 8'h2D, 0); out_chk("R3"); read_chk(8'd4, "R3");
        // R4 + R5 suspend then resume from port 2
        cyc(1, 8'd4, 8'hC0, 0); out_chk("R4");
        cyc(0, 8'd0, 8'h00, 4'b0100); out_chk("R5");
        check("R5", {30'b0, host_state}, 32'd1);
        // R6 resume ignored outside suspend
        cyc(1, 8'd4, 8'h80, 0);
        cyc(0, 8'd0, 8'h00, 4'b1111); out_chk("R6");
        check("R6", {30'b0, host_state}, 32'd2);
        // R7 simultaneous write and resume
        cyc(1, 8'd4, 8'hC0, 0);
        cyc(1, 8'd4, 8'h9F, 4'b0001); out_chk("R7");
        check("R7", {30'b0, host_state}, 32'd1);
        // R8, R10 byte 1
        cyc(1, 8'd5, 8'hFF, 0); read_chk(8'd5, "R8");
        check("R8", {24'b0, bus_rdata}, 32'h05);
        out_chk("R8");
        // R9 routing
        irq_chk(1, "R9");
        cyc(1, 8'd5, 8'h00, 0); irq_chk(1, "R9");
        // R10 reserved bytes
        cyc(1, 8'd6, 8'hFF, 0); read_chk(8'd6, "R10");
        cyc(1, 8'd7, 8'hFF, 0); read_chk(8'd7, "R10");
        // R11 unmapped
        cyc(1, 8'h20, 8'hFF, 0); read_chk(8'h20, "R11"); read_chk(8'hFF, "R11");
        // random phase
        for (int i = 0; i < 500; i++) begin
            logic [7:0] a, ra;
            a  = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 10);
            ra = 8'($urandom % 12);
            cyc($urandom % 2 == 1, a, 8'($urandom),
                ($urandom % 3 == 0) ? 4'($urandom) : 4'b0);
            out_chk("R3");
            read_chk(ra, tag_for(ra));
            irq_chk(1'($urandom), "R9");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule